// File: doc/BRIEF.md
# Protected Write Command Guard

This block sits between the host write-cycle stream of a byte-wide flash device and its page buffer. It watches every write for multi-cycle address/data unlock patterns and decides whether a plain write may go to the page buffer. It recognises five commands: arm the write guard and open a load window, drop the write guard, start a whole-array erase, enter identification mode, and leave identification mode. The write-guard bit acts as non-volatile state. It comes up set at power-on, and the block reset does not change it.

Every command begins with the same two key cycles. The first writes AAh to address 5555h. The second writes 55h to address 2AAAh. The third cycle then picks the command by writing a code byte to 5555h:

| Third-cycle code | Action |
|---|---|
| A0h | Arm the guard and open a load window |
| 90h | Enter identification mode |
| F0h | Leave identification mode |
| 80h | Extend to a six-cycle command |

A six-cycle command repeats the two key cycles and then writes a final code to 5555h. A final 20h drops the guard. A final 10h starts an erase.

While the guard is armed, a plain write is passed on only inside a load window. A load window stays open while consecutive writes arrive no more than `GAP_CYC` clock cycles apart. Command sequences follow the same spacing rule. The downstream page controller uses `load_en` to accept a write. The erase timer uses `erase_start` to begin its run. Reads in identification mode take their data from `id_data`.

Top module: `wcg_cmd_guard`

## Requirements
- R1: After reset, `id_mode` is 0, `erase_start` is 0 and no command is in progress. At power-on, `prot_on` is 1.
- R2: While `prot_on` is 1 and no load window is open, a plain write gives `load_en` = 0.
- R3: The three cycles (5555h,AAh), (2AAAh,55h), (5555h,A0h) set `prot_on` and open a load window. Later plain writes in the window give `load_en` = 1 in their own cycle. Command cycles never give `load_en` = 1.
- R4: A write k cycles after the previous write is still inside the window for k ≤ `GAP_CYC` (default 16). For k > `GAP_CYC`, the window is closed.
- R5: The six cycles (5555h,AAh), (2AAAh,55h), (5555h,80h), (5555h,AAh), (2AAAh,55h), (5555h,20h) clear `prot_on`. After that, every plain write gives `load_en` = 1 with no unlock and no time limit.
- R6: The same six cycles ending in (5555h,10h) raise `erase_start` for exactly one cycle, starting in the cycle after the last write. `prot_on` does not change.
- R7: A command cycle that comes more than `GAP_CYC` cycles after the previous cycle does not continue the sequence. It is handled as a plain write from idle.
- R8: A cycle that does not match the expected step aborts the sequence and returns to idle. That cycle is discarded (`load_en` = 0), and neither the window nor any mode changes.
- R9: The three-cycle prefix with code 90h sets `id_mode`. In that mode, `rd_addr` 0000h gives `id_data` DAh, 0001h gives C8h, and any other address gives 00h. Plain writes give `load_en` = 0.
- R10: The three-cycle prefix with code F0h clears `id_mode`. Outside identification mode, `id_data` is 00h.
- R11: Reset leaves `prot_on` at its previous value, whether 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (guard bit excluded) |
| wr_valid | input | 1 | One host write cycle in this clock |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 16 | Read address for identification data |
| prot_on | output | 1 | Write guard armed |
| load_en | output | 1 | Current write goes to the page buffer |
| erase_start | output | 1 | One-cycle erase start strobe |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification byte for `rd_addr` |

## Verification
The decoder is driven with the following patterns:

- **Full command sequences.** Each of the five commands is sent complete. This separates the third-cycle and sixth-cycle codes from one another.
- **Plain writes with and without a prior unlock.** These separate guarded behaviour from unguarded behaviour.
- **A sequence broken by a wrong step.** This shows that an abort discards the offending cycle and leaves the window alone.
- **Write spacing of exactly `GAP_CYC` and one cycle more.** These pin down the window and sequence timeout edge.
- **Resets issued with the guard set and with it cleared.** These show that the guard bit survives reset while identification mode does not.

// File: rtl/wcg_pkg.sv
package wcg_pkg;

    localparam logic [7:0] KEY1_DATA   = 8'hAA;
    localparam logic [7:0] KEY2_DATA   = 8'h55;
    localparam logic [7:0] CODE_ARM    = 8'hA0;
    localparam logic [7:0] CODE_LONG   = 8'h80;
    localparam logic [7:0] CODE_IDIN   = 8'h90;
    localparam logic [7:0] CODE_IDOUT  = 8'hF0;
    localparam logic [7:0] CODE_DISARM = 8'h20;
    localparam logic [7:0] CODE_ERASE  = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_L3,
        ST_L4,
        ST_L5
    } seq_state_t;

    typedef enum logic [3:0] {
        TK_NONE,
        TK_KEY1,
        TK_KEY2,
        TK_ARM,
        TK_LONG,
        TK_IDIN,
        TK_IDOUT,
        TK_DISARM,
        TK_ERASE
    } tok_t;

    typedef struct packed {
        seq_state_t st;
        logic       win;
        logic       idm;
        logic       ers;
    } ctl_t;

endpackage

// File: rtl/wcg_token.sv
module wcg_token
    import wcg_pkg::*;
#(
    parameter int              AW     = 16,
    parameter int              DW     = 8,
    parameter logic [AW-1:0]   KEY_LO = 'h5555,
    parameter logic [AW-1:0]   KEY_HI = 'h2AAA
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output tok_t          tok
);

    localparam int CMP_W = (DW < 8) ? DW : 8;

    logic [7:0] code;

    always_comb begin
        code = '0;
        code[CMP_W-1:0] = data[CMP_W-1:0];
    end

    always_comb begin
        tok = TK_NONE;
        if (addr == KEY_LO) begin
            case (code)
                KEY1_DATA:   tok = TK_KEY1;
                CODE_ARM:    tok = TK_ARM;
                CODE_LONG:   tok = TK_LONG;
                CODE_IDIN:   tok = TK_IDIN;
                CODE_IDOUT:  tok = TK_IDOUT;
                CODE_DISARM: tok = TK_DISARM;
                CODE_ERASE:  tok = TK_ERASE;
                default:     tok = TK_NONE;
            endcase
        end else if (addr == KEY_HI && code == KEY2_DATA) begin
            tok = TK_KEY2;
        end
    end

endmodule

// File: rtl/wcg_gap.sv
module wcg_gap #(
    parameter int GAP_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic expired
);

    localparam int CW = $clog2(GAP_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(GAP_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hit) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LIMIT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == LIMIT);

    // R4: the idle counter saturates at the limit and never passes it
    a_r4_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R4: a write always restarts the spacing window
    a_r4_hit_clears : assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !expired);

endmodule

// File: rtl/wcg_idrom.sv
module wcg_idrom #(
    parameter int            AW  = 16,
    parameter int            DW  = 8,
    parameter logic [DW-1:0] MFR = 'hDA,
    parameter logic [DW-1:0] DEV = 'hC8
) (
    input  logic          id_on,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] id_data
);

    always_comb begin
        id_data = '0;
        if (id_on) begin
            if (rd_addr == AW'(0)) begin
                id_data = MFR;
            end else if (rd_addr == AW'(1)) begin
                id_data = DEV;
            end
        end
    end

endmodule

// File: rtl/wcg_cmd_guard.sv
module wcg_cmd_guard
    import wcg_pkg::*;
#(
    parameter int            AW      = 16,
    parameter int            DW      = 8,
    parameter int            GAP_CYC = 16,
    parameter logic [AW-1:0] KEY_LO  = 'h5555,
    parameter logic [AW-1:0] KEY_HI  = 'h2AAA,
    parameter logic [DW-1:0] MFR     = 'hDA,
    parameter logic [DW-1:0] DEV     = 'hC8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic          prot_on,
    output logic          load_en,
    output logic          erase_start,
    output logic          id_mode,
    output logic [DW-1:0] id_data
);

    tok_t       tok;
    logic       gap_expired;
    ctl_t       ctl_d, ctl_q;
    logic       prot_d;
    logic       prot_q = 1'b1;
    logic       ld_c;
    seq_state_t cur_st;
    logic       win_now;

    wcg_token #(
        .AW     (AW),
        .DW     (DW),
        .KEY_LO (KEY_LO),
        .KEY_HI (KEY_HI)
    ) u_token (
        .addr (wr_addr),
        .data (wr_data),
        .tok  (tok)
    );

    wcg_gap #(
        .GAP_CYC (GAP_CYC)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (wr_valid),
        .expired (gap_expired)
    );

    wcg_idrom #(
        .AW  (AW),
        .DW  (DW),
        .MFR (MFR),
        .DEV (DEV)
    ) u_idrom (
        .id_on   (ctl_q.idm),
        .rd_addr (rd_addr),
        .id_data (id_data)
    );

    always_comb begin
        cur_st    = gap_expired ? ST_IDLE : ctl_q.st;
        win_now   = ctl_q.win && !gap_expired;
        ctl_d     = ctl_q;
        ctl_d.st  = cur_st;
        ctl_d.win = win_now;
        ctl_d.ers = 1'b0;
        prot_d    = prot_q;
        ld_c      = 1'b0;
        if (wr_valid) begin
            case (cur_st)
                ST_IDLE: begin
                    if (tok == TK_KEY1) begin
                        ctl_d.st = ST_K1;
                    end else begin
                        ld_c = !ctl_q.idm && (!prot_q || win_now);
                    end
                end
                ST_K1: begin
                    ctl_d.st = (tok == TK_KEY2) ? ST_K2 : ST_IDLE;
                end
                ST_K2: begin
                    ctl_d.st = ST_IDLE;
                    case (tok)
                        TK_ARM: begin
                            prot_d    = 1'b1;
                            ctl_d.win = 1'b1;
                        end
                        TK_LONG:  ctl_d.st  = ST_L3;
                        TK_IDIN:  ctl_d.idm = 1'b1;
                        TK_IDOUT: ctl_d.idm = 1'b0;
                        default:  ctl_d.st  = ST_IDLE;
                    endcase
                end
                ST_L3: begin
                    ctl_d.st = (tok == TK_KEY1) ? ST_L4 : ST_IDLE;
                end
                ST_L4: begin
                    ctl_d.st = (tok == TK_KEY2) ? ST_L5 : ST_IDLE;
                end
                ST_L5: begin
                    ctl_d.st = ST_IDLE;
                    if (tok == TK_DISARM) begin
                        prot_d    = 1'b0;
                        ctl_d.win = 1'b0;
                    end else if (tok == TK_ERASE) begin
                        ctl_d.ers = 1'b1;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, win: 1'b0, idm: 1'b0, ers: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // guard bit models non-volatile storage: no reset term
    always_ff @(posedge clk) begin
        prot_q <= prot_d;
    end

    assign prot_on     = prot_q;
    assign load_en     = ld_c;
    assign erase_start = ctl_q.ers;
    assign id_mode     = ctl_q.idm;

    // R6: the erase strobe lasts one cycle
    a_r6_erase_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    // R6: an erase strobe follows a final erase code write
    a_r6_erase_cause : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_start) |-> $past(wr_valid && wr_addr == KEY_LO && wr_data == DW'(CODE_ERASE)));

    // R5: the guard only drops after a disarm code write
    a_r5_disarm_cause : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(wr_valid && wr_addr == KEY_LO && wr_data == DW'(CODE_DISARM)));

    // R3: the guard only rises after an arm code write
    a_r3_arm_cause : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(wr_valid && wr_addr == KEY_LO && wr_data == DW'(CODE_ARM)));

    // R2: a guarded load needs a live spacing window
    a_r2_guarded_load : assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && prot_on) |-> !gap_expired);

    // R9: identification mode blocks page loads
    a_r9_id_blocks : assert property (@(posedge clk) disable iff (!rst_n)
        id_mode |-> !load_en);

    // R3: a load enable only accompanies a write cycle
    a_r3_load_needs_write : assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> wr_valid);

endmodule

// File: tb/tb_wcg_cmd_guard.sv
module tb_wcg_cmd_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_addr = '0;
    logic        prot_on, load_en, erase_start, id_mode;
    logic [7:0]  id_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    wcg_cmd_guard dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .prot_on     (prot_on),
        .load_en     (load_en),
        .erase_start (erase_start),
        .id_mode     (id_mode),
        .id_data     (id_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, output logic ld);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        #1 ld = load_en;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic cmd3(input logic [7:0] code, input string req);
        logic l;
        wr(16'h5555, 8'hAA, l); chk(req, l, 0);
        wr(16'h2AAA, 8'h55, l); chk(req, l, 0);
        wr(16'h5555, code,  l); chk(req, l, 0);
    endtask

    task automatic cmd6(input logic [7:0] code, input string req);
        logic l;
        cmd3(8'h80, req);
        wr(16'h5555, 8'hAA, l); chk(req, l, 0);
        wr(16'h2AAA, 8'h55, l); chk(req, l, 0);
        wr(16'h5555, code,  l); chk(req, l, 0);
    endtask

    task automatic t_reset_state();
        chk("R1 prot at power-on", prot_on, 1);
        chk("R1 id_mode", id_mode, 0);
        chk("R1 erase_start", erase_start, 0);
        chk("R1 id_data", id_data, 8'h00);
    endtask

    task automatic t_guarded_discard();
        logic l;
        wr(16'h1234, 8'h5A, l);
        chk("R2 unlocked write discarded", l, 0);
    endtask

    task automatic t_arm_and_load();
        logic l;
        cmd3(8'hA0, "R3 command cycles not loaded");
        chk("R3 prot after arm", prot_on, 1);
        wr(16'h0100, 8'h11, l); chk("R3 first load", l, 1);
        wr(16'h0101, 8'h22, l); chk("R3 second load", l, 1);
    endtask

    task automatic t_window_edge();
        logic l;
        idle(14);
        wr(16'h0102, 8'h33, l); chk("R4 gap equal to limit", l, 1);
        idle(15);
        wr(16'h0103, 8'h44, l); chk("R4 gap past limit", l, 0);
    endtask

    task automatic t_abort();
        logic l;
        idle(20);
        cmd3(8'hA0, "R8 setup");
        wr(16'h5555, 8'hAA, l); chk("R8 key cycle", l, 0);
        wr(16'h0200, 8'h33, l); chk("R8 aborting cycle discarded", l, 0);
        wr(16'h0201, 8'h44, l); chk("R8 window kept after abort", l, 1);
        chk("R8 no mode change", id_mode, 0);
    endtask

    task automatic t_seq_timeout();
        logic l;
        idle(20);
        wr(16'h5555, 8'hAA, l);
        idle(15);
        wr(16'h2AAA, 8'h55, l); chk("R7 late key treated as plain", l, 0);
        wr(16'h5555, 8'hA0, l); chk("R7 code after broken sequence", l, 0);
        wr(16'h0300, 8'h01, l); chk("R7 window not opened", l, 0);
        chk("R7 no mode change", id_mode, 0);
    endtask

    task automatic t_erase();
        idle(20);
        cmd6(8'h10, "R6 erase command cycles");
        chk("R6 erase strobe high", erase_start, 1);
        @(negedge clk);
        chk("R6 erase strobe one cycle", erase_start, 0);
        chk("R6 prot unchanged", prot_on, 1);
    endtask

    task automatic t_disarm();
        logic l;
        cmd6(8'h20, "R5 disarm command cycles");
        chk("R5 prot cleared", prot_on, 0);
        wr(16'h0400, 8'h55, l); chk("R5 free load", l, 1);
        idle(40);
        wr(16'h0401, 8'h66, l); chk("R5 free load after long gap", l, 1);
    endtask

    task automatic t_id_mode();
        logic l;
        cmd3(8'h90, "R9 entry cycles");
        chk("R9 id_mode set", id_mode, 1);
        rd_addr = 16'h0000; #1 chk("R9 maker code", id_data, 8'hDA);
        rd_addr = 16'h0001; #1 chk("R9 device code", id_data, 8'hC8);
        rd_addr = 16'h0002; #1 chk("R9 other address", id_data, 8'h00);
        wr(16'h0500, 8'h77, l); chk("R9 load blocked", l, 0);
        cmd3(8'hF0, "R10 exit cycles");
        chk("R10 id_mode cleared", id_mode, 0);
        rd_addr = 16'h0000; #1 chk("R10 id_data off", id_data, 8'h00);
        wr(16'h0501, 8'h78, l); chk("R10 loads resume", l, 1);
    endtask

    task automatic t_persist();
        cmd3(8'h90, "R11 setup");
        do_reset();
        chk("R11 prot stays clear over reset", prot_on, 0);
        chk("R1 id_mode cleared by reset", id_mode, 0);
        cmd3(8'hA0, "R11 rearm");
        do_reset();
        chk("R11 prot stays set over reset", prot_on, 1);
    endtask

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_guarded_discard();
        t_arm_and_load();
        t_window_edge();
        t_abort();
        t_seq_timeout();
        t_erase();
        t_disarm();
        t_id_mode();
        t_persist();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule